// File: doc/BRIEF.md
# SAR Conversion Handshake Controller

This block sequences one successive-approximation conversion at a time. A falling level on the acquisition input `sample_in`, seen at a clock edge while the block is idle, commits it to a conversion. The block raises `busy` and lets a programmable number of clock edges pass as a setup blanking window. It then spends DATA_W+1 counted edges resolving the result. The first counted edge presents the top trial bit on `trial_code`. Each later edge reads the comparator answer `cmp_ge` for the bit under trial, keeps or clears that bit, and offers the next lower one.

On the last counted edge the finished code is written into `result`, `busy` drops and `done` pulses for one cycle. `result` then holds its value until the next conversion completes. No back-pressure exists: the result is not a stream but a held register, and a consumer may read it at any time between `done` and the next `done`.

The asynchronous `cal` input is a hard reset. It abandons any conversion, clears the trial code and the result, and holds `busy` high. On the first clock edge after it is released, the block returns to idle.

Top module: `sar_handshake_ctrl`

## Requirements
- R1: While idle, a clock edge at which `sample_in` is 0 and was 1 at the previous edge commits a conversion, and `busy` is 1 from that edge on.
- R2: From the commit edge until `busy` falls, `sample_in` has no effect: toggling it changes neither the conversion length nor the result, and it starts no new conversion afterwards.
- R3: The first BLANK_CYC edges after the commit edge are not counted, and `trial_code` stays 0 through them. `trial_code` is also 0 whenever no bit is under trial.
- R4: A conversion uses exactly DATA_W+1 counted edges. `busy` is therefore high for BLANK_CYC+DATA_W+1 clock cycles after the commit edge (19 with the defaults).
- R5: A trial bit is kept when `cmp_ge` is 1 at the edge that decides it, and cleared otherwise. With `cmp_ge` = (input level >= `trial_code`), `result` equals the input level.
- R6: On the final counted edge, `result` takes the new code, `busy` falls and `done` is 1 for exactly that one following cycle.
- R7: `result` changes only on the final counted edge of a conversion (or by `cal`). Clocks while idle or mid-conversion leave it unchanged.
- R8: Raising `cal` drives `busy` to 1 and `trial_code` and `result` to 0 at once, without waiting for a clock edge, and abandons any conversion.
- R9: After `cal` falls, `busy` drops on the first clock edge. A level of `sample_in` held through the release starts nothing.
- R10: After counted edge k+1 (k = 0..DATA_W-1), `trial_code` holds the k decided upper bits followed by a 1 at bit DATA_W-1-k and zeros below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all sequencing on its rising edge |
| cal | input | 1 | Asynchronous abort/reset, active high |
| sample_in | input | 1 | Acquisition control; a fall while idle commits a conversion |
| cmp_ge | input | 1 | Comparator answer: 1 when input level >= `trial_code` |
| trial_code | output | DATA_W | Trial code driven to the comparison DAC |
| busy | output | 1 | High during a conversion and while `cal` holds the block |
| done | output | 1 | One-cycle pulse as `busy` falls at the end of a conversion |
| result | output | DATA_W | Last finished conversion code, held until the next one |

## Verification
The assertions take `sample_in` and `cmp_ge` to be synchronous to `clk` and settled before each rising edge. They take `cmp_ge` to be a function of the present `trial_code`, and `cal` to be raised at the start of time. The bench drives every input at falling edges and models the comparator as a continuous compare of a held level against `trial_code`. It raises `cal` at time zero and, in later tests, also between edges to probe its asynchronous effect. It toggles `sample_in` at random inside the lockout, but holds it low for the last few counted edges, so that the only falls the block can see after `busy` drops are ones the bench means.

// File: rtl/sar_hs_pkg.sv
package sar_hs_pkg;
  typedef enum logic [1:0] {
    ST_RECOVER = 2'd0,
    ST_IDLE    = 2'd1,
    ST_SETUP   = 2'd2,
    ST_CONV    = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_fall_detect.sv
module sar_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic fall
);
  logic prev_q;

  // prev_q resets low so a level held high through reset starts nothing
  always_ff @(posedge clk or posedge rst) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_in;
  end

  assign fall = prev_q & ~level_in;
endmodule

// File: rtl/sar_blank_timer.sv
module sar_blank_timer #(
  parameter int BLANK_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  generate
    if (BLANK_CYC == 0) begin : g_none
      assign expired = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(BLANK_CYC + 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or posedge rst) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= CW'(BLANK_CYC);
        else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      end

      assign expired = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/sar_bit_stepper.sv
module sar_bit_stepper #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              step,
  input  logic              cmp_ge,
  output logic [DATA_W-1:0] trial_code,
  output logic [DATA_W-1:0] result,
  output logic              finish
);
  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] mask_q, trial_q, result_q, decided;

  // bit under trial survives only if the input is at or above the trial level
  assign decided = cmp_ge ? trial_q : (trial_q & ~mask_q);
  assign finish  = step & mask_q[0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      mask_q   <= '0;
      trial_q  <= '0;
      result_q <= '0;
    end else if (start) begin
      mask_q  <= TOP_BIT;
      trial_q <= TOP_BIT;
    end else if (step) begin
      if (mask_q[0]) begin
        result_q <= decided;
        trial_q  <= '0;
        mask_q   <= '0;
      end else begin
        trial_q <= decided | (mask_q >> 1);
        mask_q  <= mask_q >> 1;
      end
    end
  end

  assign trial_code = trial_q;
  assign result     = result_q;

  p_mask_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask_q));

  p_keep_bit_r5: assert property (@(posedge clk) disable iff (rst)
    (step && cmp_ge && !mask_q[0]) |=> ((trial_q & $past(mask_q)) != '0));

  p_clear_bit_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !cmp_ge && !mask_q[0]) |=> ((trial_q & $past(mask_q)) == '0));

  p_upper_kept_r10: assert property (@(posedge clk) disable iff (rst)
    (step && !mask_q[0]) |=>
      ((trial_q & ~($past(mask_q) | ($past(mask_q) - 1'b1))) ==
       ($past(trial_q) & ~($past(mask_q) | ($past(mask_q) - 1'b1)))));

  p_result_on_finish_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_q) |-> $past(finish));
endmodule

// File: rtl/sar_handshake_ctrl.sv
module sar_handshake_ctrl
  import sar_hs_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BLANK_CYC = 2
) (
  input  logic              clk,
  input  logic              cal,
  input  logic              sample_in,
  input  logic              cmp_ge,
  output logic [DATA_W-1:0] trial_code,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  sar_state_e state_q, state_d;
  logic fall, expired, commit, start, step, finish, done_q;

  sar_fall_detect u_fall (
    .clk      (clk),
    .rst      (cal),
    .level_in (sample_in),
    .fall     (fall)
  );

  assign commit = (state_q == ST_IDLE) && fall;
  assign start  = (state_q == ST_SETUP) && expired;
  assign step   = (state_q == ST_CONV);

  sar_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk     (clk),
    .rst     (cal),
    .load    (commit),
    .expired (expired)
  );

  sar_bit_stepper #(.DATA_W(DATA_W)) u_step (
    .clk        (clk),
    .rst        (cal),
    .start      (start),
    .step       (step),
    .cmp_ge     (cmp_ge),
    .trial_code (trial_code),
    .result     (result),
    .finish     (finish)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RECOVER: state_d = ST_IDLE;
      ST_IDLE:    if (commit) state_d = ST_SETUP;
      ST_SETUP:   if (expired) state_d = ST_CONV;
      ST_CONV:    if (finish) state_d = ST_IDLE;
      default:    state_d = ST_RECOVER;
    endcase
  end

  always_ff @(posedge clk or posedge cal) begin
    if (cal) begin
      state_q <= ST_RECOVER;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  p_commit_busy_r1: assert property (@(posedge clk) disable iff (cal)
    commit |=> busy);

  p_done_on_fall_r6: assert property (@(posedge clk) disable iff (cal)
    done |-> (!busy && $past(busy)));

  p_fall_has_done_r6: assert property (@(posedge clk) disable iff (cal)
    ($fell(busy) && $past(state_q) == ST_CONV) |-> done);

  p_cal_busy_r8: assert property (@(posedge clk)
    cal |-> busy);

  p_trial_idle_zero_r3: assert property (@(posedge clk) disable iff (cal)
    (state_q != ST_CONV) |-> (trial_code == '0));
endmodule

// File: tb/sim_sar_handshake_ctrl.sv
`timescale 1ns/1ps
module sim_sar_handshake_ctrl;
  localparam int W = 16;
  localparam int B = 2;

  logic clk = 1'b0;
  logic cal, sample_in, cmp_ge, busy, done;
  logic [W-1:0] trial_code, result, level;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign cmp_ge = (level >= trial_code);

  sar_handshake_ctrl #(.DATA_W(W), .BLANK_CYC(B)) u0 (
    .clk(clk), .cal(cal), .sample_in(sample_in), .cmp_ge(cmp_ge),
    .trial_code(trial_code), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_trial(input logic [W-1:0] v, input int j);
    logic [W-1:0] hi;
    hi = ~({W{1'b1}} >> j);
    return (v & hi) | ({1'b1, {(W-1){1'b0}}} >> j);
  endfunction

  task automatic do_conv(input logic [W-1:0] lvl, input bit jitter);
    logic [W-1:0] prev;
    int n;
    @(negedge clk);
    level = lvl;
    sample_in = 1'b1;
    @(negedge clk);
    sample_in = 1'b0;
    prev = result;
    n = 0;
    @(negedge clk);
    chk(busy == 1'b1, "R1", busy, 1);
    while (busy && n < 200) begin
      n++;
      chk(result == prev, "R7", result, prev);
      if (n <= B + 1) chk(trial_code == '0, "R3", trial_code, 0);
      else if (n <= B + W + 1)
        chk(trial_code == exp_trial(lvl, n - B - 2), "R10", trial_code,
            exp_trial(lvl, n - B - 2));
      if (jitter && n < B + 12) sample_in = 1'($urandom % 2);
      else sample_in = 1'b0;
      @(negedge clk);
    end
    chk(n == B + W + 1, "R4", n, B + W + 1);
    chk(done == 1'b1, "R6", done, 1);
    chk(result == lvl, "R5", result, lvl);
    chk(trial_code == '0, "R3", trial_code, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6", done, 0);
    chk(result == lvl, "R7", result, lvl);
    chk(busy == 1'b0, "R2", busy, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    cal = 1'b1;
    sample_in = 1'b0;
    level = '0;
    repeat (3) @(negedge clk);
    // power-on state held by cal (R8)
    chk(busy == 1'b1, "R8", busy, 1);
    chk(done == 1'b0, "R8", done, 0);
    chk(result == '0, "R8", result, 0);
    chk(trial_code == '0, "R8", trial_code, 0);
    cal = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R9", busy, 0);

    // directed corners
    do_conv(16'h0000, 1'b0);
    do_conv(16'hFFFF, 1'b0);
    do_conv(16'h8000, 1'b1);
    do_conv(16'h7FFF, 1'b1);
    do_conv(16'h0001, 1'b0);

    // idle clocks leave result frozen (R7)
    held = result;
    repeat (6) begin
      level = W'($urandom);
      @(negedge clk);
      chk(result == held, "R7", result, held);
      chk(busy == 1'b0, "R2", busy, 0);
    end

    // random conversions, lockout jitter on some
    for (int i = 0; i < 24; i++) do_conv(W'($urandom), 1'($urandom % 2));

    // cal raised between edges while idle (R8)
    #5 cal = 1'b1;
    #1;
    chk(busy == 1'b1, "R8", busy, 1);
    chk(result == '0, "R8", result, 0);
    sample_in = 1'b1;
    @(negedge clk);
    cal = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R9", busy, 0);
    repeat (3) begin
      @(negedge clk);
      chk(busy == 1'b0, "R9", busy, 0);
    end
    sample_in = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R1", busy, 1);
    repeat (6) @(negedge clk);
    // cal mid-conversion between edges (R8)
    chk(trial_code != '0, "R8", trial_code, 1);
    #5 cal = 1'b1;
    #1;
    chk(trial_code == '0, "R8", trial_code, 0);
    chk(busy == 1'b1, "R8", busy, 1);
    @(negedge clk);
    cal = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R9", busy, 0);
    chk(result == '0, "R8", result, 0);

    // conversion after abort runs normally
    do_conv(16'hA5C3, 1'b1);
    do_conv(16'h5A3C, 1'b0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule